// File: doc/BRIEF.md
# Scrambled RAM Guard

This block stands between a single-port RAM that holds scrambled data and the requesters that read and write it. It keeps the key and the nonce for the scrambling map. It forwards or refuses each bus access, and it runs a sweep that fills the whole RAM with zero. Fresh key material comes from an external key source over a request/acknowledge handshake. The cipher itself is a stand-in: a fixed, key-dependent XOR map that permutes the address and masks the data word. The storage is a plain register array.

Software-style control arrives as single-cycle writes of a 3-bit command word. Bit 0 asks for a new key, bit 1 starts the zero sweep, and bit 2 seals the command path. Every request on the memory port receives exactly one response one cycle later. A refused access receives an error response and leaves no trace in the RAM. An escalation input moves the block into a terminal state that only reset leaves. In that state the key material is wiped and every access is refused.

Top module: `scr_ram_guard`

## Requirements
- R1: After reset the key and nonce are zero, `stat_o` is 0 and `key_req_o` is low. A write followed by a read of the same word returns the written data under the all-zero key.
- R2: A command write with bit 1 set starts a sweep that writes logical zero to every word, one word per cycle, for DEPTH cycles. Accesses during the sweep get an error response. At the end `stat_o[2]` (init done) is 1, and every word then reads as zero.
- R3: An accepted command with bit 0 set raises `key_req_o` on the next cycle and holds it until `key_ack_i` is sampled high. At that edge the key, the nonce and the seed-valid flag are loaded, `stat_o[0]` (key valid) becomes 1 and `stat_o[1]` takes the seed flag. `key_req_o` is low on the following cycle.
- R4: An access sampled while `key_req_o` is high gets an error response with zero read data. It neither writes the RAM nor reads it.
- R5: A word reads back the data last written to it as long as the key and nonce are unchanged. This holds after any number of key changes, and for every address at once, because the map is a bijection. A renewal that delivers identical key material leaves the stored contents readable.
- R6: When `esc_i` is high at a clock edge, `stat_o` becomes 4'b1000 (bit 3, escalated) and stays so. The key and nonce are wiped, a pending key request is dropped and a running sweep is aborted. Every access, including one sampled in the same cycle as `esc_i`, gets an error response, and all commands are ignored.
- R7: A reset leaves the escalated state, after which accesses, renewals and sweeps work normally.
- R8: A command write with bit 2 set seals the command path until reset. The bits 0 and 1 of that same write are still honoured, and later renew and init commands are ignored.
- R9: Each cycle with `mem_req_i` high is followed by exactly one cycle with `mem_rvalid_o` high. An accepted write answers with `mem_err_o` 0 and zero data, and no response appears without a request.
- R10: When bits 0 and 1 are set in one write, only the sweep starts. A renew command is ignored while a sweep runs, and an init command is ignored while a key request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_req_i | input | 1 | Access request, one access per cycle |
| mem_we_i | input | 1 | 1 = write, 0 = read |
| mem_addr_i | input | AW | Logical word address |
| mem_wdata_i | input | DW | Write data |
| mem_rvalid_o | output | 1 | Response strobe, one cycle after a request |
| mem_err_o | output | 1 | Response is an error (access refused) |
| mem_rdata_o | output | DW | Read data, zero for writes and errors |
| key_req_o | output | 1 | Key request to the key source |
| key_ack_i | input | 1 | Key source acknowledge with valid material |
| key_i | input | KW | Key delivered with the acknowledge |
| nonce_i | input | NW | Nonce delivered with the acknowledge |
| key_seed_ok_i | input | 1 | Key seed was valid |
| cfg_wr_i | input | 1 | Command write strobe |
| cfg_wdata_i | input | 3 | Command: bit 0 renew, bit 1 init, bit 2 seal |
| stat_o | output | 4 | bit 0 key valid, bit 1 seed valid, bit 2 init done, bit 3 escalated |
| esc_i | input | 1 | Escalation request |

## Verification
If the pending flag, the sweep counter or the escalation latch is wrong, the mistake shows at the ports in the next response. The fault appears as an error where success was due, or the reverse, and `stat_o` and `key_req_o` diverge in the cycle after the faulty edge. A mistake in the scrambling map or in the write gating stays hidden until that word is read back. The bench therefore reads each written word under the key it was written with, including the words written during a pending request. It sweeps all addresses with distinct data, which exposes address collisions in the map.

// File: rtl/srg_pkg.sv
package srg_pkg;
  localparam int unsigned CFG_W     = 3;
  localparam int unsigned CFG_RENEW = 0;
  localparam int unsigned CFG_INIT  = 1;
  localparam int unsigned CFG_SEAL  = 2;

  typedef struct packed {
    logic esc;
    logic init_done;
    logic seed_ok;
    logic key_ok;
  } stat_t;

  localparam int unsigned STAT_W = $bits(stat_t);
endpackage

// File: rtl/srg_scr_map.sv
module srg_scr_map #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 32,
  parameter int unsigned KW = 32,
  parameter int unsigned NW = 32
) (
  input  logic [KW-1:0] key_i,
  input  logic [NW-1:0] nonce_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] phys_o,
  output logic [DW-1:0] mask_o
);
  // address permutation: XOR with key bits keeps it a bijection
  for (genvar i = 0; i < AW; i++) begin : g_phys
    assign phys_o[i] = addr_i[i] ^ key_i[(i * 5 + 2) % KW];
  end

  // data mask depends on key, nonce and logical address
  for (genvar j = 0; j < DW; j++) begin : g_mask
    assign mask_o[j] = key_i[j % KW] ^ nonce_i[(j * 3 + 1) % NW] ^ addr_i[j % AW];
  end
endmodule

// File: rtl/srg_key_bank.sv
module srg_key_bank #(
  parameter int unsigned KW = 32,
  parameter int unsigned NW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          renew_i,
  input  logic          seal_i,
  input  logic          esc_i,
  input  logic          ack_i,
  input  logic [KW-1:0] key_i,
  input  logic [NW-1:0] nonce_i,
  input  logic          seed_ok_i,
  output logic [KW-1:0] key_o,
  output logic [NW-1:0] nonce_o,
  output logic          key_ok_o,
  output logic          seed_ok_o,
  output logic          pend_o,
  output logic          esc_o,
  output logic          open_o
);
  logic [KW-1:0] key_q, key_d;
  logic [NW-1:0] nonce_q, nonce_d;
  logic          key_ok_q, key_ok_d, seed_ok_q, seed_ok_d;
  logic          pend_q, pend_d, esc_q, esc_d, open_q, open_d;
  logic          wipe, take, key_en;

  assign wipe   = esc_i | esc_q;
  assign take   = pend_q & ack_i & ~wipe;
  assign key_en = wipe | take;

  always_comb begin
    key_d     = key_q;
    nonce_d   = nonce_q;
    key_ok_d  = key_ok_q;
    seed_ok_d = seed_ok_q;
    pend_d    = pend_q;
    esc_d     = esc_q | esc_i;
    open_d    = open_q & ~seal_i;
    if (wipe) begin
      key_d     = '0;
      nonce_d   = '0;
      key_ok_d  = 1'b0;
      seed_ok_d = 1'b0;
      pend_d    = 1'b0;
    end else if (take) begin
      key_d     = key_i;
      nonce_d   = nonce_i;
      key_ok_d  = 1'b1;
      seed_ok_d = seed_ok_i;
      pend_d    = 1'b0;
    end else if (renew_i) begin
      pend_d    = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q     <= '0;
      nonce_q   <= '0;
      key_ok_q  <= 1'b0;
      seed_ok_q <= 1'b0;
    end else if (key_en) begin
      key_q     <= key_d;
      nonce_q   <= nonce_d;
      key_ok_q  <= key_ok_d;
      seed_ok_q <= seed_ok_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      esc_q  <= 1'b0;
      open_q <= 1'b1;
    end else begin
      pend_q <= pend_d;
      esc_q  <= esc_d;
      open_q <= open_d;
    end
  end

  assign key_o     = key_q;
  assign nonce_o   = nonce_q;
  assign key_ok_o  = key_ok_q;
  assign seed_ok_o = seed_ok_q;
  assign pend_o    = pend_q;
  assign esc_o     = esc_q;
  assign open_o    = open_q;

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !ack_i && !esc_i |=> pend_q);
  p_esc_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_q |=> esc_q);
  p_esc_wipe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_q |-> (key_q == '0) && (nonce_q == '0) && !key_ok_q && !seed_ok_q && !pend_q);
  p_seal_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_q |=> !open_q);
  p_sealed_no_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_q && !pend_q |=> !pend_q);
endmodule

// File: rtl/srg_zero_sweep.sv
module srg_zero_sweep #(
  parameter int unsigned AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  output logic          busy_o,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          busy_q, busy_d, done_q, done_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          step_en;

  assign step_en = abort_i | start_i | busy_q;

  always_comb begin
    busy_d = busy_q;
    done_d = done_q;
    addr_d = addr_q;
    if (abort_i) begin
      busy_d = 1'b0;
      done_d = 1'b0;
    end else if (start_i) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      addr_d = '0;
    end else if (busy_q) begin
      if (addr_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
    end else if (step_en) begin
      busy_q <= busy_d;
      done_q <= done_d;
      addr_q <= addr_d;
    end
  end

  assign busy_o = busy_q;
  assign addr_o = addr_q;
  assign done_o = done_q;

  p_sweep_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && (addr_q == LAST) && !abort_i |=> done_q && !busy_q);
  p_sweep_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (addr_q == '0) && !done_q);
endmodule

// File: rtl/scr_ram_guard.sv
module scr_ram_guard #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 32,
  parameter int unsigned KW = 32,
  parameter int unsigned NW = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         mem_req_i,
  input  logic                         mem_we_i,
  input  logic [AW-1:0]                mem_addr_i,
  input  logic [DW-1:0]                mem_wdata_i,
  output logic                         mem_rvalid_o,
  output logic                         mem_err_o,
  output logic [DW-1:0]                mem_rdata_o,
  output logic                         key_req_o,
  input  logic                         key_ack_i,
  input  logic [KW-1:0]                key_i,
  input  logic [NW-1:0]                nonce_i,
  input  logic                         key_seed_ok_i,
  input  logic                         cfg_wr_i,
  input  logic [srg_pkg::CFG_W-1:0]    cfg_wdata_i,
  output logic [srg_pkg::STAT_W-1:0]   stat_o,
  input  logic                         esc_i
);
  import srg_pkg::*;
  localparam int unsigned DEPTH = 1 << AW;

  logic [KW-1:0] key;
  logic [NW-1:0] nonce;
  logic          key_ok, seed_ok, pend, esc_q, open;
  logic          busy, done;
  logic [AW-1:0] sw_addr, acc_phys, sw_phys;
  logic [DW-1:0] acc_mask, sw_mask;
  logic          esc_any, blocked, acc_ok, cmd_ok, renew_go, init_go, seal;
  stat_t         stat;

  assign esc_any  = esc_i | esc_q;
  assign blocked  = pend | esc_any | busy;
  assign acc_ok   = mem_req_i & ~blocked;
  assign cmd_ok   = cfg_wr_i & open & ~esc_any;
  assign init_go  = cmd_ok & cfg_wdata_i[CFG_INIT] & ~pend & ~busy;
  assign renew_go = cmd_ok & cfg_wdata_i[CFG_RENEW] & ~cfg_wdata_i[CFG_INIT] & ~pend & ~busy;
  assign seal     = cfg_wr_i & cfg_wdata_i[CFG_SEAL];

  srg_key_bank #(.KW(KW), .NW(NW)) u_keys (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .renew_i   (renew_go),
    .seal_i    (seal),
    .esc_i     (esc_i),
    .ack_i     (key_ack_i),
    .key_i     (key_i),
    .nonce_i   (nonce_i),
    .seed_ok_i (key_seed_ok_i),
    .key_o     (key),
    .nonce_o   (nonce),
    .key_ok_o  (key_ok),
    .seed_ok_o (seed_ok),
    .pend_o    (pend),
    .esc_o     (esc_q),
    .open_o    (open)
  );

  srg_zero_sweep #(.AW(AW)) u_sweep (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (init_go),
    .abort_i (esc_any),
    .busy_o  (busy),
    .addr_o  (sw_addr),
    .done_o  (done)
  );

  srg_scr_map #(.AW(AW), .DW(DW), .KW(KW), .NW(NW)) u_map_acc (
    .key_i   (key),
    .nonce_i (nonce),
    .addr_i  (mem_addr_i),
    .phys_o  (acc_phys),
    .mask_o  (acc_mask)
  );

  srg_scr_map #(.AW(AW), .DW(DW), .KW(KW), .NW(NW)) u_map_sweep (
    .key_i   (key),
    .nonce_i (nonce),
    .addr_i  (sw_addr),
    .phys_o  (sw_phys),
    .mask_o  (sw_mask)
  );

  // storage array and its single write port
  logic [DW-1:0] ram_q [DEPTH];
  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic [DW-1:0] ram_wdata;

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = acc_phys;
    ram_wdata = mem_wdata_i ^ acc_mask;
    if (busy) begin
      ram_we    = ~esc_any;
      ram_waddr = sw_phys;
      ram_wdata = sw_mask;
    end else if (acc_ok && mem_we_i) begin
      ram_we    = 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ram_we) begin
      ram_q[ram_waddr] <= ram_wdata;
    end
  end

  // response stage
  logic          rvalid_q, rvalid_d, err_q, err_d;
  logic [DW-1:0] rdata_q, rdata_d;

  always_comb begin
    rvalid_d = mem_req_i;
    err_d    = mem_req_i & blocked;
    rdata_d  = '0;
    if (acc_ok && !mem_we_i) begin
      rdata_d = ram_q[acc_phys] ^ acc_mask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      err_q    <= err_d;
      rdata_q  <= rdata_d;
    end
  end

  assign mem_rvalid_o = rvalid_q;
  assign mem_err_o    = err_q;
  assign mem_rdata_o  = rdata_q;
  assign key_req_o    = pend;

  always_comb begin
    stat.esc       = esc_q;
    stat.init_done = done;
    stat.seed_ok   = seed_ok;
    stat.key_ok    = key_ok;
  end
  assign stat_o = stat;

  p_one_rsp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |=> mem_rvalid_o);
  p_no_rsp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_req_i |=> !mem_rvalid_o);
  p_pend_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && key_req_o |=> mem_err_o && (mem_rdata_o == '0));
  p_esc_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && stat_o[3] |=> mem_err_o && (mem_rdata_o == '0));
endmodule

// File: tb/sim_scr_ram_guard.sv
`timescale 1ns/1ps
module sim_scr_ram_guard;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int KW = 32;
  localparam int NW = 32;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          rvalid, err;
  logic [DW-1:0] rdata;
  logic          key_req, key_ack, seed_ok;
  logic [KW-1:0] key_in;
  logic [NW-1:0] nonce_in;
  logic          cfg_wr;
  logic [2:0]    cfg_wd;
  logic [3:0]    stat;
  logic          esc;

  scr_ram_guard #(.AW(AW), .DW(DW), .KW(KW), .NW(NW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_req_i(mem_req), .mem_we_i(mem_we), .mem_addr_i(mem_addr), .mem_wdata_i(mem_wdata),
    .mem_rvalid_o(rvalid), .mem_err_o(err), .mem_rdata_o(rdata),
    .key_req_o(key_req), .key_ack_i(key_ack), .key_i(key_in), .nonce_i(nonce_in),
    .key_seed_ok_i(seed_ok), .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wd), .stat_o(stat), .esc_i(esc)
  );

  int total = 0;
  int bad = 0;
  string ctx = "R1";

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", ctx, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit            m_pend, m_esc, m_open, m_kok, m_sok, m_busy, m_done;
  int            m_cnt;
  logic [KW-1:0] m_key;
  logic [NW-1:0] m_nonce;
  logic [DW-1:0] m_val [DEPTH];
  bit            m_known [DEPTH];
  bit            e_rvalid, e_err, e_chk;
  logic [DW-1:0] e_rdata;

  always begin : model
    bit esc_now, blk, cmd_ok, go_init, go_renew;
    int a;
    @(posedge clk);
    if (!rst_n) begin
      m_pend = 0; m_esc = 0; m_open = 1; m_kok = 0; m_sok = 0; m_busy = 0; m_done = 0;
      m_cnt = 0; m_key = '0; m_nonce = '0;
      for (int i = 0; i < DEPTH; i++) m_known[i] = 0;
      e_rvalid = 0; e_err = 0; e_chk = 0; e_rdata = '0;
    end else begin
      esc_now = esc || m_esc;
      blk = m_pend || esc_now || m_busy;
      a = int'(mem_addr);
      e_rvalid = mem_req; e_err = mem_req && blk; e_rdata = '0; e_chk = mem_req;
      if (mem_req && !blk) begin
        if (mem_we) begin
          m_val[a] = mem_wdata; m_known[a] = 1;
        end else if (m_known[a]) begin
          e_rdata = m_val[a];
        end else begin
          e_chk = 0;
        end
      end
      cmd_ok   = cfg_wr && m_open && !esc_now;
      go_init  = cmd_ok && cfg_wd[1] && !m_pend && !m_busy;
      go_renew = cmd_ok && cfg_wd[0] && !cfg_wd[1] && !m_pend && !m_busy;
      if (cfg_wr && cfg_wd[2]) m_open = 0;
      if (esc_now) begin
        m_busy = 0; m_done = 0;
      end else if (go_init) begin
        m_busy = 1; m_done = 0; m_cnt = 0;
      end else if (m_busy) begin
        m_val[m_cnt] = '0; m_known[m_cnt] = 1;
        if (m_cnt == DEPTH - 1) begin m_busy = 0; m_done = 1; end
        else m_cnt++;
      end
      if (esc_now) begin
        m_esc = 1; m_key = '0; m_nonce = '0; m_kok = 0; m_sok = 0; m_pend = 0;
      end else if (m_pend && key_ack) begin
        if (key_in !== m_key || nonce_in !== m_nonce)
          for (int i = 0; i < DEPTH; i++) m_known[i] = 0;
        m_key = key_in; m_nonce = nonce_in; m_kok = 1; m_sok = seed_ok; m_pend = 0;
      end else if (go_renew) begin
        m_pend = 1;
      end
    end
    #1;
    chk("key_req", 64'(key_req), 64'(m_pend));
    chk("stat", 64'(stat), 64'({m_esc, m_done, m_sok, m_kok}));
    chk("rvalid", 64'(rvalid), 64'(e_rvalid));
    if (e_rvalid) chk("err", 64'(err), 64'(e_err));
    if (e_chk) chk("rdata", 64'(rdata), 64'(e_rdata));
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic acc(bit we, int a, logic [DW-1:0] d);
    mem_req = 1; mem_we = we; mem_addr = AW'(a); mem_wdata = d;
    @(negedge clk);
    mem_req = 0; mem_we = 0;
  endtask

  task automatic cmd(logic [2:0] v);
    cfg_wr = 1; cfg_wd = v;
    @(negedge clk);
    cfg_wr = 0; cfg_wd = '0;
  endtask

  task automatic give_key(logic [KW-1:0] k, logic [NW-1:0] n, bit ok);
    key_in = k; nonce_in = n; seed_ok = ok; key_ack = 1;
    @(negedge clk);
    key_ack = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; tick(3); rst_n = 1; tick(1);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired t=%0t", $time);
    summary();
  end

  initial begin : stim
    mem_req = 0; mem_we = 0; mem_addr = '0; mem_wdata = '0;
    key_ack = 0; key_in = '0; nonce_in = '0; seed_ok = 0;
    cfg_wr = 0; cfg_wd = '0; esc = 0;
    @(negedge clk);
    do_reset();

    // R1: reset state and access under the zero key
    ctx = "R1";
    tick(2);
    acc(1, 5, 32'hA5A5_0F0F); acc(0, 5, '0);
    acc(1, 63, 32'h0000_1234); acc(0, 63, '0);
    tick(1);

    // R9: back-to-back mixed accesses and idle gaps
    ctx = "R9";
    for (int i = 0; i < 8; i++) acc(1, i, DW'(i * 37 + 11));
    for (int i = 0; i < 8; i++) acc(0, 7 - i, '0);
    acc(1, 9, 32'hCAFE_0009); tick(2); acc(0, 9, '0); acc(1, 9, 32'h1); acc(0, 9, '0);
    tick(1);

    // R2: zero sweep, accesses during it are refused
    ctx = "R2";
    cmd(3'b010);
    acc(0, 1, '0); acc(1, 2, 32'hDEAD_BEEF);
    tick(DEPTH);
    for (int i = 0; i < DEPTH; i++) acc(0, i, '0);

    // R3: renewal handshake with a delayed acknowledge
    ctx = "R3";
    cmd(3'b001);
    tick(3);
    give_key(32'h3C5A_9E17, 32'h0F1E_2D3C, 1'b1);
    tick(2);

    // R5: bijection under the new key
    ctx = "R5";
    for (int i = 0; i < DEPTH; i++) acc(1, i, DW'(i));
    for (int i = 0; i < DEPTH; i++) acc(0, i, '0);

    // R4: accesses while a renewal is pending leave no trace
    ctx = "R4";
    cmd(3'b001);
    acc(1, 3, 32'hBAD0_0BAD); acc(0, 3, '0);
    give_key(32'h3C5A_9E17, 32'h0F1E_2D3C, 1'b1);
    acc(0, 3, '0); acc(0, 4, '0);

    // R10: command priority and mutual exclusion
    ctx = "R10";
    cmd(3'b011);
    tick(2); cmd(3'b001);
    tick(DEPTH);
    cmd(3'b001); cmd(3'b010);
    give_key(32'h7711_AB02, 32'h55AA_1357, 1'b0);
    acc(1, 20, 32'h2020_2020); acc(0, 20, '0);
    ctx = "R5";
    acc(1, 21, 32'h0BAD_F00D);
    cmd(3'b001); give_key(32'h0123_4567, 32'h89AB_CDEF, 1'b1);
    acc(1, 21, 32'h7E57_0021); acc(0, 21, '0); acc(0, 20, '0);

    // R6: escalation during a pending request and an access
    ctx = "R6";
    cmd(3'b001);
    esc = 1; key_in = 32'hFFFF_0000; key_ack = 1;
    acc(0, 21, '0);
    esc = 0; key_ack = 0;
    acc(0, 21, '0); acc(1, 21, 32'h1111_1111);
    cmd(3'b010); cmd(3'b001); give_key(32'h1, 32'h2, 1'b1);
    tick(3); acc(0, 0, '0);

    // R7: reset leaves the terminal state
    ctx = "R7";
    do_reset();
    acc(1, 4, 32'h4444_0004); acc(0, 4, '0);
    cmd(3'b001); tick(1); give_key(32'h9999_8888, 32'h7777_6666, 1'b1);
    acc(1, 4, 32'h0004_4444); acc(0, 4, '0);

    // R8: seal honours its own write, then blocks commands
    ctx = "R8";
    cmd(3'b101);
    give_key(32'hAAAA_5555, 32'h1234_8765, 1'b1);
    cmd(3'b001); tick(2); cmd(3'b010); tick(3);
    acc(1, 30, 32'h3030_0030); acc(0, 30, '0);
    tick(2);
    summary();
  end
endmodule